// File: doc/BRIEF.md
# Split Dual 8-bit PWM Timer

This block holds two independent 8-bit down-counters, called the low counter and the high counter. Both advance on one shared count tick. The tick comes either from a prescaled version of the block clock or from an external event strobe. Each counter has a period value and four compare values, so the block drives eight single-slope PWM outputs, each with its own duty cycle. Both counters report underflow. Only the low counter also reports per-channel compare matches and a trigger pulse that can start a data-transfer request.

Software configures the block through a plain write port. Period and compare writes go into buffer registers. A counter moves its buffered compare values into use only when it reloads, so a change in the middle of a PWM cycle cannot produce a short glitch pulse. A synchronous clear input restarts the prescaler and both counters. It forces all outputs and flags low and keeps the configuration.

Top module: `split_pwm_timer`

## Requirements
- R1: After reset, both counters hold 0, every buffered and active compare value is 0, both buffered periods are 255, the prescaler is at 0, and every output is 0.
- R2: A write with wr_addr[3]=0 targets the low counter and one with wr_addr[3]=1 targets the high counter. The sub-address wr_addr[2:0] selects the field: 0 is the period, 1 to 4 are compare channels 0 to 3, and 5 to 7 are ignored. A write only changes a buffer. A counter's active compare values take the buffered values only on that counter's reload tick.
- R3: On a tick, a counter above 0 decrements by 1. A counter at 0 loads its buffered period instead. A counter does not change between ticks.
- R4: The cycle after a reload tick, that counter's underflow output (unf_lo or unf_hi) is high for exactly one cycle.
- R5: Each PWM output is a register that takes (next count < next active compare) at every clock edge. A compare value of 0 therefore keeps the output low, and a compare value above the period keeps it high once it is active.
- R6: The cycle after a tick that moves the low counter to a value equal to active compare i, cmp_lo[i] is high for one cycle. The high counter has no compare-match outputs.
- R7: trig_lo is high the cycle after any low-counter reload tick or low compare match, and at no other time.
- R8: clk_sel encodes the tick source: 0 stopped, 1 every clock, 2/3/4 divide by 2/4/8, 5 divide by 64, 6 divide by 256, 7 event input. The prescaler counter P increments on every edge and is zeroed by reset or clear. A divide-by-N tick occurs on the edges where P mod N equals N-1.
- R9: With clk_sel=7, every clock edge that samples evt_in high is one tick.
- R10: An edge that samples clr high zeros both counters, the prescaler, the PWM outputs and all flags, and keeps every buffer and active compare value. A write in the same cycle is still accepted.
- R11: Both counters advance on the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of counters, prescaler and outputs |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address: bit 3 selects the counter, bits 2:0 select the field |
| wr_data | input | 8 | Write data |
| clk_sel | input | 3 | Tick source select |
| evt_in | input | 1 | Event strobe, one tick per cycle high when selected |
| pwm_lo | output | 4 | PWM outputs of the low counter |
| pwm_hi | output | 4 | PWM outputs of the high counter |
| unf_lo | output | 1 | Low counter underflow pulse |
| unf_hi | output | 1 | High counter underflow pulse |
| cmp_lo | output | 4 | Low counter compare-match pulses |
| trig_lo | output | 1 | Low counter transfer trigger pulse |

## Verification
A wrong count value or a lost decrement changes the spacing of the underflow pulses and shifts the PWM edges. This is visible in the very next PWM period, and it is seen at once on any channel whose compare value lies between the old and new counts. A buffer that leaks into use before reload changes a PWM output in the middle of a cycle, within one clock of the write. A prescaler out of phase shows as underflow counts that differ from the tick count over a fixed window. The bench compares every output on every cycle against a model built from the requirements, so any such error is reported at the first cycle where it reaches a port.

// File: rtl/split_pwm_timer.sv
module split_pwm_timer #(
  parameter int W   = 8,
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           wr_en,
  input  logic [3:0]     wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic [2:0]     clk_sel,
  input  logic           evt_in,
  output logic [NCH-1:0] pwm_lo,
  output logic [NCH-1:0] pwm_hi,
  output logic           unf_lo,
  output logic           unf_hi,
  output logic [NCH-1:0] cmp_lo,
  output logic           trig_lo
);
  localparam int PW = 8;
  localparam logic [W-1:0] PER_RST = {W{1'b1}};

  logic [PW-1:0]  pre;
  logic           tick;
  logic [W-1:0]   cnt     [2];
  logic [W-1:0]   cnt_nx  [2];
  logic [W-1:0]   per_buf [2];
  logic [W-1:0]   cmp_buf [2][NCH];
  logic [W-1:0]   cmp_act [2][NCH];
  logic [W-1:0]   cmp_nx  [2][NCH];
  logic [1:0]     reload;
  logic [NCH-1:0] pwm_q [2];
  logic [NCH-1:0] match;

  always_comb begin
    case (clk_sel)
      3'd0:    tick = 1'b0;
      3'd1:    tick = 1'b1;
      3'd2:    tick = pre[0];
      3'd3:    tick = &pre[1:0];
      3'd4:    tick = &pre[2:0];
      3'd5:    tick = &pre[5:0];
      3'd6:    tick = &pre[7:0];
      default: tick = evt_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   pre <= '0;
    else if (clr) pre <= '0;
    else          pre <= pre + 1'b1;

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      reload[h] = tick && !clr && (cnt[h] == '0);
      if (clr)            cnt_nx[h] = '0;
      else if (!tick)     cnt_nx[h] = cnt[h];
      else if (reload[h]) cnt_nx[h] = per_buf[h];
      else                cnt_nx[h] = cnt[h] - 1'b1;
      for (int i = 0; i < NCH; i++)
        cmp_nx[h][i] = reload[h] ? cmp_buf[h][i] : cmp_act[h][i];
    end
    for (int i = 0; i < NCH; i++)
      match[i] = tick && !clr && (cnt_nx[0] == cmp_nx[0][i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < 2; h++) begin
        cnt[h]     <= '0;
        per_buf[h] <= PER_RST;
        pwm_q[h]   <= '0;
        for (int i = 0; i < NCH; i++) begin
          cmp_buf[h][i] <= '0;
          cmp_act[h][i] <= '0;
        end
      end
      unf_lo  <= 1'b0;
      unf_hi  <= 1'b0;
      cmp_lo  <= '0;
      trig_lo <= 1'b0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        cnt[h] <= cnt_nx[h];
        for (int i = 0; i < NCH; i++) begin
          cmp_act[h][i] <= cmp_nx[h][i];
          pwm_q[h][i]   <= !clr && (cnt_nx[h] < cmp_nx[h][i]);
          if (wr_en && wr_addr[3] == h[0] && wr_addr[2:0] == 3'(i + 1))
            cmp_buf[h][i] <= wr_data;
        end
        if (wr_en && wr_addr[3] == h[0] && wr_addr[2:0] == 3'd0)
          per_buf[h] <= wr_data;
      end
      unf_lo  <= reload[0];
      unf_hi  <= reload[1];
      cmp_lo  <= match;
      trig_lo <= reload[0] || (|match);
    end
  end

  assign pwm_lo = pwm_q[0];
  assign pwm_hi = pwm_q[1];

  p_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt[0] != '0) |=> cnt[0] == $past(cnt[0]) - 1'b1);
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt[1] == '0) |=> cnt[1] == $past(per_buf[1]));
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !clr) |=> $stable(cnt[0]) && $stable(cnt[1]));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt[0] == '0) && (cnt[1] == '0) && (pwm_lo == '0) && (pwm_hi == '0)
            && !unf_lo && !unf_hi && (cmp_lo == '0) && !trig_lo);
  p_trig_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_lo |-> unf_lo || (|cmp_lo));
  p_unf_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    unf_hi |-> cnt[1] == $past(per_buf[1]));
  p_cmp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && !clr && cnt[0] == '0) |=> $stable(cmp_act[0][0]));
endmodule

// File: tb/split_pwm_timer_bench.sv
`timescale 1ns/1ps
module split_pwm_timer_bench;
  logic clk = 0, rst_n = 0, clr = 0, wr_en = 0, evt_in = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] clk_sel = 0;
  logic [3:0] pwm_lo, pwm_hi, cmp_lo;
  logic unf_lo, unf_hi, trig_lo;

  int checks = 0, errors = 0, n_unf_lo = 0, n_unf_hi = 0;
  bit done = 0;

  logic [7:0] m_pre;
  logic [7:0] m_cnt [2];
  logic [7:0] m_pb [2];
  logic [7:0] m_cb [2][4];
  logic [7:0] m_ca [2][4];
  logic [3:0] e_pwm [2];
  logic [3:0] e_cmp;
  logic e_unf [2];
  logic e_trig;

  split_pwm_timer u_split_pwm_timer (.clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .clk_sel(clk_sel), .evt_in(evt_in),
    .pwm_lo(pwm_lo), .pwm_hi(pwm_hi), .unf_lo(unf_lo), .unf_hi(unf_hi),
    .cmp_lo(cmp_lo), .trig_lo(trig_lo));

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic tick_of(logic [2:0] sel, logic [7:0] p, logic ev);
    case (sel)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return (p % 2) == 1;
      3'd3: return (p % 4) == 3;
      3'd4: return (p % 8) == 7;
      3'd5: return (p % 64) == 63;
      3'd6: return p == 8'd255;
      default: return ev;
    endcase
  endfunction

  function automatic int unf_count(int ticks, int per);
    return (ticks == 0) ? 0 : 1 + (ticks - 1) / (per + 1);
  endfunction

  task automatic model_reset();
    m_pre = 0; e_cmp = 0; e_trig = 0;
    for (int h = 0; h < 2; h++) begin
      m_cnt[h] = 0; m_pb[h] = 8'hFF; e_pwm[h] = 0; e_unf[h] = 0;
      for (int i = 0; i < 4; i++) begin m_cb[h][i] = 0; m_ca[h][i] = 0; end
    end
  endtask

  task automatic model_step();
    logic t, rl;
    logic [7:0] nc;
    logic [7:0] ncmp [4];
    t = tick_of(clk_sel, m_pre, evt_in);
    e_cmp = 0; e_trig = 0;
    for (int h = 0; h < 2; h++) begin
      rl = t && !clr && m_cnt[h] == 0;
      nc = clr ? 8'd0 : !t ? m_cnt[h] : rl ? m_pb[h] : m_cnt[h] - 8'd1;
      for (int i = 0; i < 4; i++) begin
        ncmp[i] = rl ? m_cb[h][i] : m_ca[h][i];
        e_pwm[h][i] = !clr && (nc < ncmp[i]);
        if (h == 0) e_cmp[i] = t && !clr && nc == ncmp[i];
        m_ca[h][i] = ncmp[i];
      end
      e_unf[h] = rl;
      m_cnt[h] = nc;
      if (h == 0) e_trig = rl || (|e_cmp);
    end
    if (wr_en) begin
      if (wr_addr[2:0] == 0) m_pb[wr_addr[3]] = wr_data;
      else if (wr_addr[2:0] <= 4) m_cb[wr_addr[3]][wr_addr[2:0] - 1] = wr_data;
    end
    m_pre = clr ? 8'd0 : m_pre + 8'd1;
  endtask

  task automatic cyc(logic c, logic we, logic [3:0] a, logic [7:0] d, logic [2:0] s, logic ev);
    @(negedge clk);
    clr = c; wr_en = we; wr_addr = a; wr_data = d; clk_sel = s; evt_in = ev;
    @(posedge clk);
    model_step();
    #1;
    check("R5 pwm_lo", pwm_lo, e_pwm[0]);
    check("R5 pwm_hi", pwm_hi, e_pwm[1]);
    check("R4 unf_lo", unf_lo, e_unf[0]);
    check("R4 unf_hi", unf_hi, e_unf[1]);
    check("R6 cmp_lo", cmp_lo, e_cmp);
    check("R7 trig_lo", trig_lo, e_trig);
    if (unf_lo) n_unf_lo++;
    if (unf_hi) n_unf_hi++;
  endtask

  task automatic idle(int n, logic [2:0] s);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, s, 0);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    cyc(0, 1, a, d, 3'd0, 0);
  endtask

  task automatic div_window(logic [2:0] s, int n, int per);
    cyc(1, 0, 0, 0, 3'd0, 0);
    n_unf_lo = 0; n_unf_hi = 0;
    idle(n, s);
    idle(2, 3'd0);
    check("R8 divider unf_lo count", n_unf_lo, unf_count(n / (s == 1 ? 1 : s == 2 ? 2 : s == 3 ? 4 : s == 4 ? 8 : s == 5 ? 64 : 256), per));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    #23 rst_n = 1;
    #1;
    check("R1 reset outputs", {pwm_lo, pwm_hi, unf_lo, unf_hi, cmp_lo, trig_lo}, 0);
    idle(3, 3'd0);
    check("R1 stopped after reset", {pwm_lo, pwm_hi, unf_lo, unf_hi}, 0);

    wr(4'h0, 8'd4);
    wr(4'h1, 8'd2);
    wr(4'h2, 8'd0);
    wr(4'h3, 8'd9);
    wr(4'h8, 8'd3);
    wr(4'h9, 8'd2);
    wr(4'hD, 8'd77);
    check("R2 buffered compare not yet active", pwm_lo, 4'b0000);
    cyc(0, 0, 0, 0, 3'd1, 0);
    check("R3 reload pulse low", unf_lo, 1'b1);
    check("R11 reload pulse high same tick", unf_hi, 1'b1);
    check("R5 compare above period high", pwm_lo[2], 1'b1);
    check("R5 compare zero low", pwm_lo[1], 1'b0);
    n_unf_lo = 0; n_unf_hi = 0;
    idle(20, 3'd1);
    check("R3 low period 4 unf count", n_unf_lo, 4);
    check("R11 high period 3 unf count", n_unf_hi, 5);

    idle(1, 3'd0);
    n_unf_lo = 0;
    for (int k = 0; k < 30; k++) cyc(0, 0, 0, 0, 3'd7, (k % 3) == 0);
    idle(2, 3'd0);
    check("R9 event ticks unf count", n_unf_lo, 2);

    div_window(3'd2, 40, 4);
    div_window(3'd3, 80, 4);
    div_window(3'd4, 200, 4);
    div_window(3'd5, 1300, 4);
    div_window(3'd6, 2600, 4);

    cyc(1, 1, 4'h1, 8'd3, 3'd1, 0);
    check("R10 clear zeros outputs", {pwm_lo, pwm_hi, unf_lo, unf_hi, cmp_lo, trig_lo}, 0);

    for (int k = 0; k < 24000; k++) begin
      logic [2:0] s;
      int r;
      r = $urandom_range(0, 99);
      s = (k % 600 < 300) ? 3'd1 : 3'($urandom_range(0, 7));
      if (k % 600 >= 300) s = clk_sel == 0 && r < 90 ? 3'd0 : s;
      if (r < 2) cyc(1, 0, 0, 0, s, 0);
      else if (r < 20) cyc(0, 1, 4'($urandom_range(0, 15)), (r < 8) ? 8'($urandom_range(0, 12)) : 8'($urandom),
                           s, 1'($urandom));
      else cyc(0, 0, 0, 0, s, 1'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule